// File: doc/BRIEF.md
# Triggered Sample Pipeline with Accepted-Event Buffers

This block is the digital readout stage that follows a multi-channel digitizer. Every sample strobe it takes one unsigned 12-bit value from each of 64 channels and writes them into a circular store. The store holds 160 samples, which at a 40 MHz strobe covers a 4 µs trigger decision time. A Level-1 accept selects a short window of older samples, fixed by a latency parameter, for all channels at once. That window is copied into one of five event buffers. During the copy each value has its channel baseline removed, and each channel is marked as kept or dropped against a threshold.

The buffers drain in the order they were filled through a formatter. It sends a valid/ready word stream: a header, then each kept channel with its samples, then a trailer. When all five buffers are occupied the block raises a busy flag. Any accept that arrives while busy is set is discarded and counted. An initialize input returns the store and the buffer pool to their empty state without a full reset.

Top module: `trig_readout`

## Requirements
- R1: An accept in a cycle where n samples have been stored since the last initialize captures stored samples n-LAT through n-LAT+WIN-1 (LAT=150, WIN=4 by default). This holds when n is at least LAT. The samples are sent in ascending order.
- R2: Each captured value is the sample minus the channel baseline. A sample below its baseline gives zero.
- R3: A channel is sent only if at least one of its WIN values after subtraction is strictly greater than the threshold. Channels are sent in ascending channel number.
- R4: Each output word is 18 bits, with the tag in bits 17:16 and the payload in bits 15:0. Tag 00 is the header, 01 a channel word (the payload is the channel number), 10 a sample (the payload is the value, zero-extended) and 11 the trailer (the payload is the number of channels sent). Every event is header, then for each kept channel its channel word followed by WIN samples, then trailer.
- R5: The header payload is a 16-bit count of events already sent since reset or initialize, starting at 0.
- R6: busy is high exactly when five captured events are waiting or being sent. It falls once the trailer of an event has been accepted.
- R7: An accept while busy is high changes nothing in the buffers or the stream. It adds one to err_count.
- R8: Events leave in the order their accepts were taken.
- R9: Initialize empties all buffers, abandons any event in progress, clears the stored-sample count and the event count, and leaves err_count unchanged. busy and out_valid are low in the following cycle.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable.
- R11: After reset, busy and out_valid are low and err_count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Initialize: clears pointers and buffers |
| samp_valid | input | 1 | Sample strobe, stores adc_data |
| adc_data | input | 768 | 64 samples of 12 bits, channel c at bits 12c+11:12c |
| l1_accept | input | 1 | Level-1 accept |
| baseline | input | 768 | Per-channel baseline, same layout as adc_data |
| threshold | input | 12 | Keep threshold after subtraction |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | out_data holds a word |
| out_data | output | 18 | Tagged output word |
| busy | output | 1 | No free event buffer |
| err_count | output | 16 | Accepts dropped while busy |

## Verification
The hardest condition to reach is a full buffer pool with an accept still arriving, followed by an in-order drain. The stimulus gets there by holding out_ready low, issuing five accepts a few cycles apart, and then issuing a sixth. Only then is the stream released, and the queued events must come out in arrival order. A second difficult case is an initialize that lands while events are waiting. The bench waits LAT fresh samples after it before accepting again, so that the captured window refers only to data written after the pointer restart. Channel patterns include a lane that always clamps to zero, one exactly at threshold, one just above it, and one at full scale.

// File: rtl/trigro_pkg.sv
package trigro_pkg;
    typedef enum logic [1:0] {
        TAG_HDR  = 2'b00,
        TAG_CHAN = 2'b01,
        TAG_SAMP = 2'b10,
        TAG_TRL  = 2'b11
    } tag_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_HDR,
        F_SCAN,
        F_CHAN,
        F_DATA,
        F_TRL
    } fst_e;

    localparam int OUT_W = 18;
endpackage

// File: rtl/tr_pipe.sv
module tr_pipe #(
    parameter int NCH   = 64,
    parameter int DW    = 12,
    parameter int DEPTH = 160,
    parameter int LAT   = 150,
    parameter int WIN   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init,
    input  logic                  samp_valid,
    input  logic [NCH*DW-1:0]     samp_in,
    output logic [WIN*NCH*DW-1:0] win_out
);
    localparam int SW  = NCH * DW;
    localparam int PW  = $clog2(DEPTH);
    localparam int AW  = PW + 1;
    localparam int OFS = DEPTH - LAT;

    typedef struct packed {
        logic [PW-1:0] wp;
    } st_t;

    st_t st_d, st_q;
    logic [SW-1:0] ring_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (init) begin
            st_d.wp = '0;
        end else if (samp_valid) begin
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (samp_valid && !init) ring_q[st_q.wp] <= samp_in;
    end

    // One read tap per window position, each offset from the write pointer.
    for (genvar k = 0; k < WIN; k++) begin : g_tap
        logic [AW-1:0] sum;
        logic [PW-1:0] addr;
        always_comb begin
            sum  = {1'b0, st_q.wp} + AW'(OFS + k);
            addr = (sum >= AW'(DEPTH)) ? PW'(sum - AW'(DEPTH)) : PW'(sum);
        end
        assign win_out[k*SW +: SW] = ring_q[addr];
    end
endmodule

// File: rtl/tr_pool.sv
module tr_pool #(
    parameter int NCH  = 64,
    parameter int DW   = 12,
    parameter int WIN  = 4,
    parameter int NBUF = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init,
    input  logic                  accept,
    input  logic [WIN*NCH*DW-1:0] win_in,
    input  logic [NCH*DW-1:0]     base_in,
    input  logic [DW-1:0]         thr,
    input  logic                  release_i,
    input  logic [((WIN > 1) ? $clog2(WIN) : 1)-1:0] rd_k,
    input  logic [$clog2(NCH)-1:0] rd_ch,
    output logic                  busy,
    output logic                  avail,
    output logic [NCH-1:0]        head_mask,
    output logic [DW-1:0]         rd_sample,
    output logic [15:0]           err_count
);
    localparam int SW  = NCH * DW;
    localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int CNW = $clog2(NBUF + 1);
    localparam int BI  = ((NBUF * WIN) > 1) ? $clog2(NBUF * WIN) : 1;

    typedef struct packed {
        logic [IW-1:0]  wr;
        logic [IW-1:0]  rd;
        logic [CNW-1:0] cnt;
        logic [15:0]    err;
    } st_t;

    st_t st_d, st_q;
    logic [SW-1:0]  bmem [NBUF*WIN];
    logic [NCH-1:0] mask_mem [NBUF];
    logic [WIN*SW-1:0] sub_w;
    logic [NCH-1:0]    keep;
    logic take, rel;

    // Baseline removal with clamp at zero, and the per-channel keep decision.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [WIN-1:0] hit;
        for (genvar k = 0; k < WIN; k++) begin : g_k
            logic [DW-1:0] raw, bl, v;
            assign raw = win_in[k*SW + ch*DW +: DW];
            assign bl  = base_in[ch*DW +: DW];
            assign v   = (raw > bl) ? raw - bl : '0;
            assign sub_w[k*SW + ch*DW +: DW] = v;
            assign hit[k] = (v > thr);
        end
        assign keep[ch] = |hit;
    end

    assign busy  = (st_q.cnt == CNW'(NBUF));
    assign avail = (st_q.cnt != '0);
    assign take  = accept && !busy && !init;
    assign rel   = release_i && avail && !init;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] x);
        return (x == IW'(NBUF - 1)) ? '0 : x + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (accept && busy && !init) st_d.err = st_q.err + 16'd1;
        if (init) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (take) st_d.wr = nxt(st_q.wr);
            if (rel)  st_d.rd = nxt(st_q.rd);
            st_d.cnt = st_q.cnt + CNW'(take) - CNW'(rel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (take) begin
            for (int k = 0; k < WIN; k++) begin
                bmem[BI'(int'(st_q.wr) * WIN + k)] <= sub_w[k*SW +: SW];
            end
            mask_mem[st_q.wr] <= keep;
        end
    end

    logic [SW-1:0] rword;
    assign rword     = bmem[BI'(int'(st_q.rd) * WIN + int'(rd_k))];
    assign rd_sample = rword[int'(rd_ch)*DW +: DW];
    assign head_mask = mask_mem[st_q.rd];
    assign err_count = st_q.err;
endmodule

// File: rtl/tr_fmt.sv
module tr_fmt
    import trigro_pkg::*;
#(
    parameter int NCH = 64,
    parameter int DW  = 12,
    parameter int WIN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   init,
    input  logic                   avail,
    input  logic [NCH-1:0]         head_mask,
    input  logic [DW-1:0]          rd_sample,
    input  logic                   out_ready,
    output logic                   release_o,
    output logic [((WIN > 1) ? $clog2(WIN) : 1)-1:0] rd_k,
    output logic [$clog2(NCH)-1:0] rd_ch,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_data
);
    localparam int KW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int CW = $clog2(NCH);

    typedef struct packed {
        fst_e           st;
        logic [NCH-1:0] rem;
        logic [CW-1:0]  ch;
        logic [KW-1:0]  k;
        logic [15:0]    evc;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] low;
    logic [15:0]   nkept;
    logic          hs;

    always_comb begin
        low = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (st_q.rem[i]) low = CW'(i);
        end
    end

    always_comb begin
        nkept = '0;
        for (int i = 0; i < NCH; i++) nkept = nkept + 16'(head_mask[i]);
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        case (st_q.st)
            F_HDR:  begin out_valid = 1'b1; out_data = {TAG_HDR, st_q.evc}; end
            F_CHAN: begin out_valid = 1'b1; out_data = {TAG_CHAN, 16'(st_q.ch)}; end
            F_DATA: begin out_valid = 1'b1; out_data = {TAG_SAMP, 16'(rd_sample)}; end
            F_TRL:  begin out_valid = 1'b1; out_data = {TAG_TRL, nkept}; end
            default: ;
        endcase
    end

    assign hs    = out_valid && out_ready;
    assign rd_k  = st_q.k;
    assign rd_ch = st_q.ch;

    always_comb begin
        st_d      = st_q;
        release_o = 1'b0;
        case (st_q.st)
            F_IDLE: if (avail) st_d.st = F_HDR;
            F_HDR: if (hs) begin
                st_d.rem = head_mask;
                st_d.st  = F_SCAN;
            end
            F_SCAN: begin
                if (st_q.rem == '0) begin
                    st_d.st = F_TRL;
                end else begin
                    st_d.ch = low;
                    st_d.st = F_CHAN;
                end
            end
            F_CHAN: if (hs) begin
                st_d.k  = '0;
                st_d.st = F_DATA;
            end
            F_DATA: if (hs) begin
                if (st_q.k == KW'(WIN - 1)) begin
                    st_d.rem[st_q.ch] = 1'b0;
                    st_d.st = F_SCAN;
                end else begin
                    st_d.k = st_q.k + 1'b1;
                end
            end
            F_TRL: if (hs) begin
                release_o = 1'b1;
                st_d.evc  = st_q.evc + 16'd1;
                st_d.st   = F_IDLE;
            end
            default: st_d.st = F_IDLE;
        endcase
        if (init) begin
            st_d      = '0;
            st_d.st   = F_IDLE;
            release_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.st <= F_IDLE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/trig_readout.sv
module trig_readout
    import trigro_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int DW    = 12,
    parameter int DEPTH = 160,
    parameter int LAT   = 150,
    parameter int WIN   = 4,
    parameter int NBUF  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              samp_valid,
    input  logic [NCH*DW-1:0] adc_data,
    input  logic              l1_accept,
    input  logic [NCH*DW-1:0] baseline,
    input  logic [DW-1:0]     threshold,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [17:0]       out_data,
    output logic              busy,
    output logic [15:0]       err_count
);
    localparam int KW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int CW = $clog2(NCH);

    logic [WIN*NCH*DW-1:0] win;
    logic                  avail, rel;
    logic [NCH-1:0]        hmask;
    logic [DW-1:0]         rsamp;
    logic [KW-1:0]         rk;
    logic [CW-1:0]         rch;

    tr_pipe #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH), .LAT(LAT), .WIN(WIN)) u_pipe (
        .clk(clk), .rst_n(rst_n), .init(init), .samp_valid(samp_valid),
        .samp_in(adc_data), .win_out(win)
    );

    tr_pool #(.NCH(NCH), .DW(DW), .WIN(WIN), .NBUF(NBUF)) u_pool (
        .clk(clk), .rst_n(rst_n), .init(init), .accept(l1_accept),
        .win_in(win), .base_in(baseline), .thr(threshold),
        .release_i(rel), .rd_k(rk), .rd_ch(rch),
        .busy(busy), .avail(avail), .head_mask(hmask),
        .rd_sample(rsamp), .err_count(err_count)
    );

    tr_fmt #(.NCH(NCH), .DW(DW), .WIN(WIN)) u_fmt (
        .clk(clk), .rst_n(rst_n), .init(init), .avail(avail),
        .head_mask(hmask), .rd_sample(rsamp), .out_ready(out_ready),
        .release_o(rel), .rd_k(rk), .rd_ch(rch),
        .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/trig_readout_chk.sv
module trig_readout_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        init,
    input logic        l1_accept,
    input logic        out_ready,
    input logic        out_valid,
    input logic [17:0] out_data,
    input logic        busy,
    input logic [15:0] err_count
);
    a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n || init)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    a_r7_err_step: assert property (@(posedge clk) disable iff (!rst_n || init)
        l1_accept && busy |=> err_count == $past(err_count) + 16'd1);

    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n || init)
        !(l1_accept && busy) |=> $stable(err_count));

    a_r9_init_empty: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !busy && !out_valid);

    a_r6_busy_cause: assert property (@(posedge clk) disable iff (!rst_n || init)
        $rose(busy) |-> $past(l1_accept));

    a_r4_hdr_once: assert property (@(posedge clk) disable iff (!rst_n || init)
        out_valid && out_ready && out_data[17:16] == 2'b00
        |=> !(out_valid && out_data[17:16] == 2'b00));
endmodule

bind trig_readout trig_readout_chk u_chk (
    .clk(clk), .rst_n(rst_n), .init(init), .l1_accept(l1_accept),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .busy(busy), .err_count(err_count)
);

// File: tb/sim_trig_readout.sv
module sim_trig_readout;
    localparam int NCH = 64, DW = 12, DEPTH = 160, LAT = 150, WIN = 4, NBUF = 5;
    localparam int THR = 50;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, init, samp_valid, l1_accept, out_ready;
    logic [NCH*DW-1:0] adc_data, baseline;
    logic [DW-1:0]     threshold;
    logic              out_valid, busy;
    logic [17:0]       out_data;
    logic [15:0]       err_count;

    trig_readout u0 (
        .clk(clk), .rst_n(rst_n), .init(init), .samp_valid(samp_valid),
        .adc_data(adc_data), .l1_accept(l1_accept), .baseline(baseline),
        .threshold(threshold), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .busy(busy), .err_count(err_count)
    );

    int checks = 0, fails = 0;
    int nsamp = 0, evc_m = 0, occ_m = 0, ready_mode = 0;
    bit done = 0;
    logic [17:0] expq [$];

    function automatic int basev(int c);
        if (c == 63) return 0;
        if (c < 60 && (c % 7) == 3) return 4000;
        return 200 + c * 4;
    endfunction

    function automatic int pat(int t, int c);
        if (c == 63) return 4095;
        if (c == 62) return basev(c) + THR;
        if (c == 61) return basev(c) + THR + 1;
        return 200 + c * 4 + ((t * 5 + c * 3) % 21) + ((((t + 2 * c) % 37) == 0) ? 400 : 0);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_event();
        int kept = 0;
        int v [WIN];
        bit any;
        expq.push_back({2'b00, 16'(evc_m)});
        for (int c = 0; c < NCH; c++) begin
            any = 0;
            for (int k = 0; k < WIN; k++) begin
                v[k] = pat(nsamp - LAT + k, c) - basev(c);
                if (v[k] < 0) v[k] = 0;
                if (v[k] > THR) any = 1;
            end
            if (any) begin
                kept++;
                expq.push_back({2'b01, 16'(c)});
                for (int k = 0; k < WIN; k++) expq.push_back({2'b10, 16'(v[k])});
            end
        end
        expq.push_back({2'b11, 16'(kept)});
    endtask

    task automatic step(bit acc);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) adc_data[c*DW +: DW] = DW'(pat(nsamp, c));
        samp_valid = 1'b1;
        l1_accept  = acc;
        init       = 1'b0;
        if (acc && occ_m < NBUF) begin
            push_event();
            occ_m++;
            evc_m++;
        end
        nsamp++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    // Monitor: drives out_ready and compares handshaken words with the queue.
    initial begin
        logic [17:0] e;
        logic [15:0] lf = 16'hACE1;
        string req;
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            out_ready = (ready_mode == 1) || (ready_mode == 2 && lf[0]);
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R4 unexpected word", int'(out_data), -1);
                end else begin
                    e = expq.pop_front();
                    case (e[17:16])
                        2'b00:   req = "R5 R8 header";
                        2'b01:   req = "R3 channel";
                        2'b10:   req = "R1 R2 sample";
                        default: req = "R4 trailer";
                    endcase
                    chk(out_data == e, req, int'(out_data), int'(e));
                    if (e[17:16] == 2'b11) occ_m--;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int e0;
        rst_n = 1'b0; init = 1'b0; samp_valid = 1'b0; l1_accept = 1'b0;
        adc_data = '0;
        threshold = DW'(THR);
        for (int c = 0; c < NCH; c++) baseline[c*DW +: DW] = DW'(basev(c));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R11 busy", busy, 0);
        chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
        chk(err_count == 16'd0, "R11 err_count", err_count, 0);

        run(DEPTH + 10);
        ready_mode = 1;
        step(1); run(120);
        chk(expq.size() == 0, "R4 event drained", expq.size(), 0);

        ready_mode = 2;
        for (int i = 0; i < 4; i++) begin
            step(1); run(150 + i * 7);
            chk(expq.size() == 0, "R4 event drained random ready", expq.size(), 0);
        end

        // Back-to-back accepts.
        step(1); step(1); run(300);
        chk(expq.size() == 0, "R8 adjacent accepts drained", expq.size(), 0);

        // Fill the pool with the stream stalled.
        ready_mode = 0;
        run(3);
        for (int i = 0; i < NBUF; i++) begin step(1); run(3); end
        chk(busy == 1'b1, "R6 busy when full", busy, 1);
        e0 = int'(err_count);
        step(1); run(1);
        chk(int'(err_count) == e0 + 1, "R7 dropped accept counted", err_count, e0 + 1);
        chk(busy == 1'b1, "R7 busy unchanged", busy, 1);
        ready_mode = 1;
        run(600);
        chk(expq.size() == 0, "R8 fifo order drain", expq.size(), 0);
        chk(busy == 1'b0, "R6 busy released", busy, 0);

        // Initialize with events waiting.
        ready_mode = 0;
        step(1); step(1); run(2);
        e0 = int'(err_count);
        @(negedge clk);
        samp_valid = 1'b1; l1_accept = 1'b0; init = 1'b1;
        @(negedge clk);
        init = 1'b0;
        chk(busy == 1'b0, "R9 busy after init", busy, 0);
        chk(out_valid == 1'b0, "R9 out_valid after init", out_valid, 0);
        chk(int'(err_count) == e0, "R9 err_count kept", err_count, e0);
        expq.delete();
        occ_m = 0;
        evc_m = 0;
        run(LAT + 3);
        chk(out_valid == 1'b0, "R9 no stale event", out_valid, 0);
        ready_mode = 2;
        step(1); run(250);
        chk(expq.size() == 0, "R5 count restarted", expq.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule